// File: doc/BRIEF.md
# Paged Flash Address Translator

This block turns a 16-bit processor logical address into a 23-bit global physical address for banked program memory. Program memory is organised in 16K pages, each named by an 8-bit page number, and it occupies the upper half of the global space. A populated device therefore uses the highest page numbers, and a larger device extends downward from page $FF.

The logical space has three 16K flash regions. The region at $C000–$FFFF always shows page $FF. The region at $4000–$7FFF always shows page $FD. The middle region, $8000–$BFFF, is a window onto whichever page is held in an 8-bit page-select register. The processor reads and writes that register at logical address $0030.

Translation is combinational within the access cycle. Only the page-select register holds state. When the window uses a page number below the lowest populated page, the translator still produces the address and raises an out-of-range flag. The lowest populated page is set by a parameter and defaults to $E0.

Top module: `pflash_xlate`

## Requirements
- R1: With `acc_en` high and `log_addr` in $4000–$7FFF, `flash_sel` is 1 and `glb_addr` = $400000 + ($FD << 14) + `log_addr[13:0]`.
- R2: With `acc_en` high and `log_addr` in $C000–$FFFF, `flash_sel` is 1 and `glb_addr` = $400000 + ($FF << 14) + `log_addr[13:0]`.
- R3: With `acc_en` high and `log_addr` in $8000–$BFFF, `flash_sel` is 1 and `glb_addr` = $400000 + (page register << 14) + `log_addr[13:0]`.
- R4: After reset the page register holds $FE.
- R5: For `log_addr` below $4000, `flash_sel` and `page_oor` are 0 and `glb_addr` is `log_addr` zero-extended to 23 bits.
- R6: A write (`acc_en`=1, `acc_wr`=1, `log_addr`=$0030) loads `wr_data` into the page register at the next rising clock edge. The page value in use during that write cycle is the old one, and accesses from the next cycle on use the new value.
- R7: A read (`acc_en`=1, `acc_wr`=0, `log_addr`=$0030) drives the page register value on `page_rdata`. In every other cycle `page_rdata` is 0.
- R8: A write to any address other than $0030, or any cycle with `acc_en` low, leaves the page register unchanged.
- R9: `page_oor` is 1 exactly when `flash_sel` is 1 and the page in use is below the lowest valid page (default $E0). Page $E0 itself is in range.
- R10: With `acc_en` low, `flash_sel` and `page_oor` are 0. `glb_addr` is still formed from `log_addr` by the rules of R1, R2, R3 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access strobe, high for a bus access this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| log_addr | input | 16 | Processor logical address |
| wr_data | input | 8 | Write data for the page register |
| glb_addr | output | 23 | Global physical address |
| flash_sel | output | 1 | Access falls in a flash region |
| page_oor | output | 1 | Page in use is below the lowest valid page |
| page_rdata | output | 8 | Page register readback |

## Verification
Addresses are placed at both edges and in the interior of every region. This separates the four-way decode from the offset pass-through, and a wrong boundary comparison shows up at $3FFF/$4000 or $BFFF/$C000. Page writes of $E0, $DF and $10 exercise the out-of-range threshold at its exact edge. Writes to a neighbouring address, and with the strobe low, show whether the register decode is too loose. A long pseudo-random run of mixed reads and writes is compared every cycle against a behavioural model, which catches stale or early page updates in the window.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

  // Logical region picked by the two top address bits
  typedef enum logic [1:0] {
    RGN_LOW    = 2'b00,
    RGN_FIX_LO = 2'b01,
    RGN_WIN    = 2'b10,
    RGN_FIX_HI = 2'b11
  } rgn_e;

  typedef struct packed {
    logic hit_flash;
    logic hit_reg;
    rgn_e rgn;
  } dec_s;

endpackage

// File: rtl/pflash_rst_sync.sv
module pflash_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pflash_decode.sv
module pflash_decode
  import pflash_pkg::*;
#(
  parameter int              LA_W     = 16,
  parameter logic [LA_W-1:0] REG_ADDR = 16'h0030
) (
  input  logic            acc_en,
  input  logic [LA_W-1:0] log_addr,
  output dec_s            dec_o
);

  rgn_e rgn;

  always_comb begin
    rgn             = rgn_e'(log_addr[LA_W-1 -: 2]);
    dec_o.rgn       = rgn;
    dec_o.hit_flash = acc_en && (rgn != RGN_LOW);
    dec_o.hit_reg   = acc_en && (log_addr == REG_ADDR);
  end

endmodule

// File: rtl/pflash_page_reg.sv
module pflash_page_reg #(
  parameter int                PAGE_W     = 8,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 8'hFE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [PAGE_W-1:0] page_o
);

  logic [PAGE_W-1:0] page_q;
  logic [PAGE_W-1:0] page_d;

  always_comb begin
    page_d = page_q;
    if (wr_en) begin
      page_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page_q <= RESET_PAGE;
    end else begin
      page_q <= page_d;
    end
  end

  assign page_o = page_q;

endmodule

// File: rtl/pflash_compose.sv
module pflash_compose
  import pflash_pkg::*;
#(
  parameter int                LA_W       = 16,
  parameter int                GA_W       = 23,
  parameter int                PAGE_W     = 8,
  parameter logic [PAGE_W-1:0] FIX_LO_PG  = 8'hFD,
  parameter logic [PAGE_W-1:0] FIX_HI_PG  = 8'hFF,
  parameter logic [PAGE_W-1:0] LOW_VALID  = 8'hE0
) (
  input  rgn_e              rgn_i,
  input  logic              hit_flash_i,
  input  logic [LA_W-1:0]   log_addr,
  input  logic [PAGE_W-1:0] win_page,
  output logic [GA_W-1:0]   glb_addr,
  output logic              page_oor
);

  localparam int OFS_W = LA_W - 2;
  localparam int FL_W  = 1 + PAGE_W + OFS_W;

  logic [PAGE_W-1:0] page_sel;
  logic [FL_W-1:0]   flash_addr;
  logic [GA_W-1:0]   flash_glb;

  always_comb begin
    case (rgn_i)
      RGN_FIX_LO: page_sel = FIX_LO_PG;
      RGN_WIN:    page_sel = win_page;
      RGN_FIX_HI: page_sel = FIX_HI_PG;
      default:    page_sel = '0;
    endcase
    flash_addr = {1'b1, page_sel, log_addr[OFS_W-1:0]};
  end

  generate
    if (GA_W > FL_W) begin : g_pad
      assign flash_glb = {{(GA_W-FL_W){1'b0}}, flash_addr};
    end else begin : g_exact
      assign flash_glb = flash_addr[GA_W-1:0];
    end
  endgenerate

  always_comb begin
    if (rgn_i == RGN_LOW) begin
      glb_addr = GA_W'(log_addr);
    end else begin
      glb_addr = flash_glb;
    end
    page_oor = hit_flash_i && (page_sel < LOW_VALID);
  end

endmodule

// File: rtl/pflash_xlate.sv
module pflash_xlate
  import pflash_pkg::*;
#(
  parameter int                LA_W       = 16,
  parameter int                GA_W       = 23,
  parameter int                PAGE_W     = 8,
  parameter logic [LA_W-1:0]   REG_ADDR   = 16'h0030,
  parameter logic [PAGE_W-1:0] RESET_PAGE = 8'hFE,
  parameter logic [PAGE_W-1:0] FIX_LO_PG  = 8'hFD,
  parameter logic [PAGE_W-1:0] FIX_HI_PG  = 8'hFF,
  parameter logic [PAGE_W-1:0] LOW_VALID  = 8'hE0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [LA_W-1:0]   log_addr,
  input  logic [PAGE_W-1:0] wr_data,
  output logic [GA_W-1:0]   glb_addr,
  output logic              flash_sel,
  output logic              page_oor,
  output logic [PAGE_W-1:0] page_rdata
);

  logic              rst_sync_n;
  dec_s              dec;
  logic              page_we;
  logic [PAGE_W-1:0] page_q;

  pflash_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pflash_decode #(.LA_W(LA_W), .REG_ADDR(REG_ADDR)) u_dec (
    .acc_en   (acc_en),
    .log_addr (log_addr),
    .dec_o    (dec)
  );

  assign page_we = dec.hit_reg && acc_wr;

  pflash_page_reg #(.PAGE_W(PAGE_W), .RESET_PAGE(RESET_PAGE)) u_page (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_en   (page_we),
    .wr_data (wr_data),
    .page_o  (page_q)
  );

  pflash_compose #(
    .LA_W(LA_W), .GA_W(GA_W), .PAGE_W(PAGE_W),
    .FIX_LO_PG(FIX_LO_PG), .FIX_HI_PG(FIX_HI_PG), .LOW_VALID(LOW_VALID)
  ) u_comp (
    .rgn_i       (dec.rgn),
    .hit_flash_i (dec.hit_flash),
    .log_addr    (log_addr),
    .win_page    (page_q),
    .glb_addr    (glb_addr),
    .page_oor    (page_oor)
  );

  assign flash_sel  = dec.hit_flash;
  assign page_rdata = (dec.hit_reg && !acc_wr) ? page_q : '0;

endmodule

// File: rtl/pflash_xlate_chk.sv
module pflash_xlate_chk #(
  parameter int LA_W   = 16,
  parameter int GA_W   = 23,
  parameter int PAGE_W = 8
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              acc_en,
  input logic              acc_wr,
  input logic [LA_W-1:0]   log_addr,
  input logic [PAGE_W-1:0] wr_data,
  input logic [GA_W-1:0]   glb_addr,
  input logic              flash_sel,
  input logic              page_oor,
  input logic [PAGE_W-1:0] page_q
);

  logic reg_wr;
  assign reg_wr = acc_en && acc_wr && (log_addr == 16'h0030);

  assert_fixed_lo_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_en && log_addr[15:14] == 2'b01) |-> (flash_sel && glb_addr[22] && glb_addr[21:14] == 8'hFD));

  assert_fixed_hi_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_en && log_addr[15:14] == 2'b11) |-> (flash_sel && glb_addr[21:14] == 8'hFF));

  assert_window_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (acc_en && log_addr[15:14] == 2'b10) |-> (flash_sel && glb_addr[21:14] == page_q));

  assert_nonflash_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (log_addr[15:14] == 2'b00) |-> (!flash_sel && !page_oor && glb_addr[22:16] == 7'd0));

  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_wr |=> (page_q == $past(wr_data)));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !reg_wr |=> $stable(page_q));

  assert_oor_sel_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    page_oor |-> flash_sel);

  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_en |-> (!flash_sel && !page_oor));

endmodule

bind pflash_xlate pflash_xlate_chk #(.LA_W(LA_W), .GA_W(GA_W), .PAGE_W(PAGE_W)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .log_addr   (log_addr),
  .wr_data    (wr_data),
  .glb_addr   (glb_addr),
  .flash_sel  (flash_sel),
  .page_oor   (page_oor),
  .page_q     (page_q)
);

// File: tb/pflash_xlate_tb.sv
`timescale 1ns/1ps
module pflash_xlate_tb_top;

  logic        clk;
  logic        rst_n;
  logic        acc_en;
  logic        acc_wr;
  logic [15:0] log_addr;
  logic [7:0]  wr_data;
  logic [22:0] glb_addr;
  logic        flash_sel;
  logic        page_oor;
  logic [7:0]  page_rdata;

  int n_vec;
  int n_bad;
  int ref_page;

  pflash_xlate dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .log_addr   (log_addr),
    .wr_data    (wr_data),
    .glb_addr   (glb_addr),
    .flash_sel  (flash_sel),
    .page_oor   (page_oor),
    .page_rdata (page_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
  endtask

  // One access: drive at negedge, compare with the model, then advance the model at posedge
  task automatic apply(input bit en, input bit wr, input int addr, input int data, input string tag);
    int e_glb, e_sel, e_oor, e_rd, pg;
    @(negedge clk);
    acc_en = en; acc_wr = wr; log_addr = addr[15:0]; wr_data = data[7:0];
    #1;
    if (addr < 'h4000) begin
      e_glb = addr; e_sel = 0; pg = -1;
    end else begin
      if (addr < 'h8000)      pg = 'hFD;
      else if (addr < 'hC000) pg = ref_page;
      else                    pg = 'hFF;
      e_glb = 'h400000 + pg * 'h4000 + (addr % 'h4000);
      e_sel = en ? 1 : 0;
    end
    e_oor = (e_sel == 1 && pg < 'hE0) ? 1 : 0;
    e_rd  = (en && !wr && addr == 'h30) ? ref_page : 0;
    n_vec++;
    if (int'(glb_addr) != e_glb || int'(flash_sel) != e_sel ||
        int'(page_oor) != e_oor || int'(page_rdata) != e_rd) begin
      n_bad++;
      $display("FAIL %s addr=%h: got glb=%h sel=%0d oor=%0d rd=%h exp glb=%h sel=%0d oor=%0d rd=%h",
               tag, addr, glb_addr, flash_sel, page_oor, page_rdata, e_glb, e_sel, e_oor, e_rd);
    end
    @(posedge clk);
    if (en && wr && addr == 'h30) ref_page = data % 256;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end

  initial begin
    int lfsr;
    n_vec = 0; n_bad = 0; ref_page = 'hFE;
    acc_en = 0; acc_wr = 0; log_addr = '0; wr_data = '0;
    rst_n = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (5) @(posedge clk);

    apply(1, 0, 'h0030, 0, "R4 reset page readback");
    apply(1, 0, 'h8000, 0, "R4 R3 window at reset page");
    apply(1, 0, 'h4000, 0, "R1 fixed low start");
    apply(1, 0, 'h7FFF, 0, "R1 fixed low end");
    apply(1, 0, 'h5A5A, 0, "R1 fixed low interior");
    apply(1, 0, 'hC000, 0, "R2 fixed high start");
    apply(1, 0, 'hFFFF, 0, "R2 fixed high end");
    apply(1, 0, 'hBFFF, 0, "R3 window end");
    apply(1, 0, 'h0000, 0, "R5 bottom");
    apply(1, 0, 'h3FFF, 0, "R5 below flash edge");
    apply(1, 1, 'h0030, 'hE3, "R6 page write");
    apply(1, 0, 'h8123, 0, "R6 R3 new page in window");
    apply(1, 0, 'h0030, 0, "R7 readback after write");
    apply(1, 0, 'h0031, 0, "R7 neighbour read is zero");
    apply(1, 1, 'h0031, 'h22, "R8 neighbour write");
    apply(0, 1, 'h0030, 'h11, "R8 write with strobe low");
    apply(1, 0, 'h0030, 0, "R8 page unchanged");
    apply(1, 1, 'h0030, 'h10, "R9 write low page");
    apply(1, 0, 'h9000, 0, "R9 window out of range");
    apply(1, 0, 'hD000, 0, "R9 fixed page in range");
    apply(1, 0, 'h1000, 0, "R9 R5 non-flash no flag");
    apply(1, 1, 'h0030, 'hE0, "R9 write boundary page");
    apply(1, 0, 'hA000, 0, "R9 boundary page in range");
    apply(1, 1, 'h0030, 'hDF, "R9 write just below");
    apply(1, 0, 'hA001, 0, "R9 just below flagged");
    apply(0, 0, 'hA002, 0, "R10 strobe low window");
    apply(0, 0, 'h4444, 0, "R10 strobe low fixed");

    lfsr = 'hACE1;
    for (int i = 0; i < 3000; i++) begin
      int a, d;
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 'hFFFF;
      a = lfsr;
      d = (lfsr >> 3) & 'hFF;
      if ((i % 7) == 0) a = 'h0030;
      apply((i % 11) != 0, (i % 3) == 0, a, d, "R3 R6 random mix");
    end

    report();
    $finish;
  end

endmodule